// File: doc/BRIEF.md
# Deferred Store Write Buffer

This block sits between the memory stage of a pipeline and a single-ported cache data array. It removes the second cycle a store would normally need. A store does only its tag check in its own cycle. If the store hits, its address, byte mask and data are parked in a single pending slot. The array write for that slot happens later, in the cycle of the next store, while that store does its own tag check and so leaves the data port idle.

Loads use the data port in their own cycle. The array answers one cycle later. If a load names the same full address as the parked store, the parked bytes are laid over the array word, one byte at a time. A store that hits the word already parked is folded into the slot and costs no array write.

Two idle-cycle paths empty the slot into the array. The first is a drain request. The second is a refill request for the line that holds the parked word: the refill is held off until the parked word has been written.

Top module: `sdw_store_defer`

## Requirements
- R1: The block never stalls a store, and a hitting store's own data does not reach the array in its own cycle. In that cycle the array word is left unchanged.
- R2: The slot holds one store: its full address and its data. An array write of the slot changes only the bytes whose mask bit is set (bit i covers data bits 8i+7..8i). Array address = {index, word offset}, the low IDX_W+OFF_W bits of the address.
- R3: When a store arrives while the slot is full and names a different address, the slot is written into the array in that same cycle. This holds whether the new store hits or misses.
- R4: A store that misses in the tag check is never parked. After it, the slot is empty unless it was folded as in R7.
- R5: A load returns its data one cycle after the request, with ld_valid high. If its full address (tag included) equals the slot's address, the parked bytes are returned. An address with equal index and offset but a different tag is served from the array alone.
- R6: On a matching load, only the bytes the slot's mask covers come from the slot. All other bytes come from the array word.
- R7: A hitting store to the slot's address merges its masked bytes into the slot and widens the mask. No array write happens in that cycle.
- R8: On a cycle with no request, drain_req writes a full slot into the array and empties it. A drain with an empty slot writes nothing.
- R9: refill_gnt is high only on a cycle with no request, and only if the slot does not hold a word of line refill_idx. If the slot does hold such a word, that cycle writes the slot into the array and empties it, so the grant follows on the next request.
- R10: Reset empties the slot. After reset no drain writes the array, and loads see the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load or store is presented this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | TAG_W+IDX_W+OFF_W | Word address {tag, index, word offset} |
| req_be | input | DATA_W/8 | Store byte mask |
| req_wdata | input | DATA_W | Store data |
| tag_hit | input | 1 | Tag check result for this cycle's store |
| drain_req | input | 1 | Ask to flush the slot on an idle cycle |
| refill_req | input | 1 | A line refill wants to start |
| refill_idx | input | IDX_W | Index of the line being refilled |
| refill_gnt | output | 1 | The refill may start this cycle |
| ld_valid | output | 1 | Load data is on ld_data |
| ld_data | output | DATA_W | Load result |
| arr_en | output | 1 | Data array port enable |
| arr_we | output | 1 | Data array write |
| arr_addr | output | IDX_W+OFF_W | Data array word address |
| arr_be | output | DATA_W/8 | Data array byte write mask |
| arr_wdata | output | DATA_W | Data array write data |
| arr_rdata | input | DATA_W | Data array read word, one cycle after a read |

## Verification
The bench builds the block with a 4-bit tag, a 2-bit index, a 1-bit word offset and 32-bit data. That gives an array of eight words, which the bench models with nonzero start values, so a stale array word can always be told apart from a parked one. The short tag lets two addresses share an array word while differing only in tag, which exercises the full-address match. With the single offset bit, two words share a line, so the refill conflict can be tested against a line that holds the parked word and against one that does not.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   localparam int unsigned SDW_BYTE_W = 8;

   typedef enum logic [1:0] {
      SDW_NO_COMMIT   = 2'd0,
      SDW_STORE_SLOT  = 2'd1,
      SDW_IDLE_SLOT   = 2'd2
   } sdw_commit_e;
endpackage

// File: rtl/sdw_pend_reg.sv
module sdw_pend_reg #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  park_new,
   input  logic                  fold_in,
   input  logic                  empty_out,
   input  logic [ADDR_W-1:0]     new_addr,
   input  logic [DATA_W/8-1:0]   new_be,
   input  logic [DATA_W-1:0]     new_data,
   output logic                  slot_v,
   output logic [ADDR_W-1:0]     slot_addr,
   output logic [DATA_W/8-1:0]   slot_be,
   output logic [DATA_W-1:0]     slot_data
);
   import sdw_pkg::*;
   localparam int unsigned NB = DATA_W / SDW_BYTE_W;

   logic [DATA_W-1:0] folded;

   for (genvar b = 0; b < NB; b++) begin : g_fold
      assign folded[b*SDW_BYTE_W +: SDW_BYTE_W] = new_be[b]
         ? new_data[b*SDW_BYTE_W +: SDW_BYTE_W]
         : slot_data[b*SDW_BYTE_W +: SDW_BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_v    <= 1'b0;
         slot_addr <= '0;
         slot_be   <= '0;
         slot_data <= '0;
      end else if (fold_in) begin
         slot_be   <= slot_be | new_be;
         slot_data <= folded;
      end else if (park_new) begin
         slot_v    <= 1'b1;
         slot_addr <= new_addr;
         slot_be   <= new_be;
         slot_data <= new_data;
      end else if (empty_out) begin
         slot_v    <= 1'b0;
      end
   end
endmodule

// File: rtl/sdw_port_mux.sv
module sdw_port_mux #(
   parameter int unsigned ARR_AW = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  commit,
   input  logic                  rd_req,
   input  logic [ARR_AW-1:0]     slot_arr_addr,
   input  logic [ARR_AW-1:0]     req_arr_addr,
   input  logic [DATA_W/8-1:0]   slot_be,
   input  logic [DATA_W-1:0]     slot_data,
   output logic                  arr_en,
   output logic                  arr_we,
   output logic [ARR_AW-1:0]     arr_addr,
   output logic [DATA_W/8-1:0]   arr_be,
   output logic [DATA_W-1:0]     arr_wdata
);
   always_comb begin
      arr_en    = commit | rd_req;
      arr_we    = commit;
      arr_addr  = commit ? slot_arr_addr : req_arr_addr;
      arr_be    = commit ? slot_be : '0;
      arr_wdata = slot_data;
   end
endmodule

// File: rtl/sdw_ld_bypass.sv
module sdw_ld_bypass #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_take,
   input  logic                  ld_match,
   input  logic [DATA_W/8-1:0]   slot_be,
   input  logic [DATA_W-1:0]     slot_data,
   input  logic [DATA_W-1:0]     arr_rdata,
   output logic                  ld_valid,
   output logic [DATA_W-1:0]     ld_data
);
   import sdw_pkg::*;
   localparam int unsigned NB = DATA_W / SDW_BYTE_W;

   logic [NB-1:0]     cap_mask;
   logic [DATA_W-1:0] cap_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid <= 1'b0;
         cap_mask <= '0;
         cap_data <= '0;
      end else begin
         ld_valid <= ld_take;
         if (ld_take) begin
            cap_mask <= ld_match ? slot_be : '0;
            cap_data <= slot_data;
         end
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign ld_data[b*SDW_BYTE_W +: SDW_BYTE_W] = cap_mask[b]
         ? cap_data[b*SDW_BYTE_W +: SDW_BYTE_W]
         : arr_rdata[b*SDW_BYTE_W +: SDW_BYTE_W];
   end
endmodule

// File: rtl/sdw_store_defer.sv
module sdw_store_defer #(
   parameter int unsigned TAG_W  = 20,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned ARR_AW = IDX_W + OFF_W,
   localparam int unsigned ADDR_W = TAG_W + ARR_AW,
   localparam int unsigned BE_W   = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_is_store,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [BE_W-1:0]    req_be,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               tag_hit,
   input  logic               drain_req,
   input  logic               refill_req,
   input  logic [IDX_W-1:0]   refill_idx,
   output logic               refill_gnt,
   output logic               ld_valid,
   output logic [DATA_W-1:0]  ld_data,
   output logic               arr_en,
   output logic               arr_we,
   output logic [ARR_AW-1:0]  arr_addr,
   output logic [BE_W-1:0]    arr_be,
   output logic [DATA_W-1:0]  arr_wdata,
   input  logic [DATA_W-1:0]  arr_rdata
);
   import sdw_pkg::*;

   if (DATA_W < SDW_BYTE_W || DATA_W % SDW_BYTE_W != 0) begin : g_bad_data
      $error("sdw_store_defer: DATA_W must be a whole number of bytes");
   end
   if (IDX_W < 1 || TAG_W < 1) begin : g_bad_addr
      $error("sdw_store_defer: TAG_W and IDX_W must be at least 1");
   end

   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr;
   logic [BE_W-1:0]   pend_be;
   logic [DATA_W-1:0] pend_data;

   logic        is_st, is_ld, same_word, st_hit, fold, line_clash;
   sdw_commit_e commit_src;

   always_comb begin
      is_st      = req_valid & req_is_store;
      is_ld      = req_valid & ~req_is_store;
      same_word  = pend_v & (req_addr == pend_addr);
      st_hit     = is_st & tag_hit;
      fold       = st_hit & same_word;
      line_clash = pend_v & (pend_addr[ARR_AW-1:OFF_W] == refill_idx);
      if (is_st && pend_v && !fold)
         commit_src = SDW_STORE_SLOT;
      else if (!req_valid && pend_v && (drain_req || (refill_req && line_clash)))
         commit_src = SDW_IDLE_SLOT;
      else
         commit_src = SDW_NO_COMMIT;
      refill_gnt = refill_req & ~req_valid & ~line_clash;
   end

   sdw_pend_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pend_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .park_new  (st_hit),
      .fold_in   (fold),
      .empty_out (commit_src != SDW_NO_COMMIT),
      .new_addr  (req_addr),
      .new_be    (req_be),
      .new_data  (req_wdata),
      .slot_v    (pend_v),
      .slot_addr (pend_addr),
      .slot_be   (pend_be),
      .slot_data (pend_data)
   );

   sdw_port_mux #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) mux_i (
      .commit        (commit_src != SDW_NO_COMMIT),
      .rd_req        (is_ld),
      .slot_arr_addr (pend_addr[ARR_AW-1:0]),
      .req_arr_addr  (req_addr[ARR_AW-1:0]),
      .slot_be       (pend_be),
      .slot_data     (pend_data),
      .arr_en        (arr_en),
      .arr_we        (arr_we),
      .arr_addr      (arr_addr),
      .arr_be        (arr_be),
      .arr_wdata     (arr_wdata)
   );

   sdw_ld_bypass #(.DATA_W(DATA_W)) byp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_take   (is_ld),
      .ld_match  (same_word),
      .slot_be   (pend_be),
      .slot_data (pend_data),
      .arr_rdata (arr_rdata),
      .ld_valid  (ld_valid),
      .ld_data   (ld_data)
   );
endmodule

// File: rtl/sdw_store_defer_chk.sv
module sdw_store_defer_chk #(
   parameter int unsigned TAG_W  = 20,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned OFF_W  = 2,
   localparam int unsigned ARR_AW = IDX_W + OFF_W,
   localparam int unsigned ADDR_W = TAG_W + ARR_AW
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_is_store,
   input logic [ADDR_W-1:0] req_addr,
   input logic              tag_hit,
   input logic              drain_req,
   input logic              refill_gnt,
   input logic [IDX_W-1:0]  refill_idx,
   input logic              arr_we,
   input logic [ARR_AW-1:0] arr_addr,
   input logic              ld_valid,
   input logic              pend_v,
   input logic [ADDR_W-1:0] pend_addr
);
   // R1: a write never takes the port from a load
   a_r1_load_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !(req_valid && !req_is_store));

   // R3: a differing store commits the slot at the slot's array address
   a_r3_store_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_store && pend_v && req_addr != pend_addr)
      |-> (arr_we && arr_addr == pend_addr[ARR_AW-1:0]));

   // R4: a missing store leaves the slot empty
   a_r4_miss_not_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_store && !tag_hit) |=> !pend_v);

   // R5: load answers one cycle later
   a_r5_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_store) |=> ld_valid);

   // R7: folding store writes nothing and keeps the slot
   a_r7_fold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_store && tag_hit && pend_v && req_addr == pend_addr)
      |-> !arr_we);

   // R8: drain on an idle cycle empties the slot
   a_r8_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && drain_req && pend_v) |=> !pend_v);

   // R9: no grant while the slot holds a word of the refilled line
   a_r9_refill_safe: assert property (@(posedge clk) disable iff (!rst_n)
      refill_gnt |-> !(pend_v && pend_addr[ARR_AW-1:OFF_W] == refill_idx));

   // R10: leaving reset the slot is empty
   a_r10_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pend_v);
endmodule

bind sdw_store_defer sdw_store_defer_chk #(
   .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_is_store (req_is_store),
   .req_addr     (req_addr),
   .tag_hit      (tag_hit),
   .drain_req    (drain_req),
   .refill_gnt   (refill_gnt),
   .refill_idx   (refill_idx),
   .arr_we       (arr_we),
   .arr_addr     (arr_addr),
   .ld_valid     (ld_valid),
   .pend_v       (pend_v),
   .pend_addr    (pend_addr)
);

// File: tb/sdw_store_defer_tb.sv
`timescale 1ns/1ps
module sdw_store_defer_tb_top;
   localparam int TW = 4, IW = 2, OW = 1, DW = 32;
   localparam int AW = TW + IW + OW;
   localparam int RW = IW + OW;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 0, req_is_store = 0, tag_hit = 0;
   logic          drain_req = 0, refill_req = 0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_be = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [IW-1:0] refill_idx = '0;
   logic          refill_gnt, ld_valid, arr_en, arr_we;
   logic [DW-1:0] ld_data, arr_wdata, arr_rdata;
   logic [RW-1:0] arr_addr;
   logic [3:0]    arr_be;

   int checks = 0, errors = 0;
   logic [DW-1:0] mem [8];

   always #2.5 clk = ~clk;

   sdw_store_defer #(.TAG_W(TW), .IDX_W(IW), .OFF_W(OW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .tag_hit(tag_hit),
      .drain_req(drain_req), .refill_req(refill_req), .refill_idx(refill_idx),
      .refill_gnt(refill_gnt), .ld_valid(ld_valid), .ld_data(ld_data),
      .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr), .arr_be(arr_be),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata));

   // data array model: single port, synchronous read, byte writes
   always @(posedge clk) begin
      if (arr_en) begin
         if (arr_we) begin
            for (int b = 0; b < 4; b++)
               if (arr_be[b]) mem[arr_addr][b*8 +: 8] <= arr_wdata[b*8 +: 8];
         end else begin
            arr_rdata <= mem[arr_addr];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [3:0] be, input logic [DW-1:0] d, input logic h);
      req_valid = (op == 2'd1) || (op == 2'd2);
      req_is_store = (op == 2'd2);
      req_addr = a; req_be = be; req_wdata = d; tag_hit = h;
   endtask

   task automatic idle();
      req_valid = 0; req_is_store = 0; tag_hit = 0; drain_req = 0; refill_req = 0;
   endtask

   // op: 1 load, 2 store. For stores exp[0] = expected arr_we in that cycle.
   typedef struct packed {
      logic [1:0]    op;
      logic [6:0]    addr;
      logic [3:0]    be;
      logic [31:0]   data;
      logic          hit;
      logic [31:0]   exp;
      logic [3:0]    req;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{2'd2, 7'h10, 4'hF, 32'hAAAA0000, 1'b1, 32'h0,        4'd1}, // R1 park, no write
      '{2'd1, 7'h10, 4'h0, 32'h0,        1'b0, 32'hAAAA0000, 4'd5}, // R5 bypass
      '{2'd1, 7'h00, 4'h0, 32'h0,        1'b0, 32'h11111111, 4'd5}, // R5 other tag
      '{2'd1, 7'h11, 4'h0, 32'h0,        1'b0, 32'h22222222, 4'd1}, // R1 plain read
      '{2'd2, 7'h10, 4'h3, 32'h0000BBBB, 1'b1, 32'h0,        4'd7}, // R7 fold
      '{2'd1, 7'h10, 4'h0, 32'h0,        1'b0, 32'hAAAABBBB, 4'd7}, // R7 folded value
      '{2'd2, 7'h13, 4'hC, 32'hCCCC0000, 1'b1, 32'h1,        4'd3}, // R3 commit on store
      '{2'd1, 7'h13, 4'h0, 32'h0,        1'b0, 32'hCCCC4444, 4'd6}, // R6 byte merge
      '{2'd1, 7'h10, 4'h0, 32'h0,        1'b0, 32'hAAAABBBB, 4'd3}, // R3 in array
      '{2'd2, 7'h15, 4'hF, 32'hDDDDDDDD, 1'b0, 32'h1,        4'd4}, // R4 miss commits
      '{2'd1, 7'h15, 4'h0, 32'h0,        1'b0, 32'h66666666, 4'd4}, // R4 not parked
      '{2'd1, 7'h13, 4'h0, 32'h0,        1'b0, 32'hCCCC4444, 4'd2}  // R2 masked write
   };

   initial begin
      for (int i = 0; i < 8; i++) mem[i] = 32'h11111111 * (i + 1);
      repeat (3) @(negedge clk);
      // R10: reset state at the ports
      chk(!ld_valid && !arr_en && !refill_gnt, "R10", {29'b0, ld_valid, arr_en, refill_gnt}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < 12; v++) begin
         @(negedge clk);
         drive(VEC[v].op, VEC[v].addr, VEC[v].be, VEC[v].data, VEC[v].hit);
         #1;
         if (VEC[v].op == 2'd2)
            chk(arr_we == VEC[v].exp[0], $sformatf("R%0d store port", VEC[v].req),
                {31'b0, arr_we}, VEC[v].exp);
         @(negedge clk);
         if (VEC[v].op == 2'd1)
            chk(ld_valid && ld_data == VEC[v].exp, $sformatf("R%0d load", VEC[v].req),
                ld_data, VEC[v].exp);
         idle();
      end

      // R1: parked store leaves array word alone; R8 drain commits it
      @(negedge clk); drive(2'd2, 7'h14, 4'hF, 32'h12345678, 1'b1);
      @(negedge clk); idle();
      chk(mem[4] == 32'h55555555, "R1 no early write", mem[4], 32'h55555555);
      @(negedge clk);
      chk(mem[4] == 32'h55555555, "R8 no write without drain", mem[4], 32'h55555555);
      drain_req = 1; #1;
      chk(arr_we == 1'b1, "R8 drain writes", {31'b0, arr_we}, 1);
      @(negedge clk); idle();
      chk(mem[4] == 32'h12345678, "R8 drained value", mem[4], 32'h12345678);
      drain_req = 1; #1;
      chk(arr_we == 1'b0, "R8 slot emptied", {31'b0, arr_we}, 0);
      @(negedge clk); idle();

      // R9: refill of an unrelated line is granted at once
      drive(2'd2, 7'h16, 4'hF, 32'h99999999, 1'b1);
      @(negedge clk); idle();
      refill_req = 1; refill_idx = 2'd1; #1;
      chk(refill_gnt && !arr_we, "R9 other line", {30'b0, refill_gnt, arr_we}, 2);
      @(negedge clk);
      refill_idx = 2'd3; #1;
      chk(!refill_gnt && arr_we, "R9 held for commit", {30'b0, refill_gnt, arr_we}, 1);
      @(negedge clk);
      chk(mem[6] == 32'h99999999, "R9 commit first", mem[6], 32'h99999999);
      #1;
      chk(refill_gnt, "R9 granted after", {31'b0, refill_gnt}, 1);
      @(negedge clk); idle();

      // R10: reset discards a parked store
      drive(2'd2, 7'h17, 4'hF, 32'hEEEEEEEE, 1'b1);
      @(negedge clk); idle();
      rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      drain_req = 1; #1;
      chk(!arr_we, "R10 nothing to drain", {31'b0, arr_we}, 0);
      @(negedge clk); idle();
      drive(2'd1, 7'h17, 4'h0, 32'h0, 1'b0);
      @(negedge clk); idle();
      chk(ld_valid && ld_data == 32'h88888888, "R10 load sees array", ld_data, 32'h88888888);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule